// File: doc/BRIEF.md
# Power-Off Sequencing Controller

This controller moves a system back and forth between a powered run state and a deep power-off state each time an already synchronized, single-cycle button pulse arrives. It drives the main supply enable and an active-low I/O reset toward the processor. It watches two signals from the processor side: an active-high reset-drive output, which stays high until the processor is running on stable clocks, and a memory-refresh strobe.

On wake, the supply turns on in the same cycle as the press. The I/O reset is held for a programmable number of clock cycles and then released. The controller then waits for the synchronized reset-drive signal to fall before it declares the run state.

On power-off, the I/O reset is asserted at once. The supply is removed only after a fixed number of refresh strobes, two by default. An interlock refuses to start power-off while reset-drive is high or while the release delay is still running. Such a press is remembered in a one-deep pending flag and is carried out in the first run cycle in which it is allowed. This removes the race where a press lands just as the processor leaves reset. An external reset pulse that arrives while the system is off is treated as a wake request.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: In state OFF, a cycle with `btn_pulse` high drives `supply_en` high in that same cycle, and `state_o` reads POWER_UP_DELAY (code 1) in the next cycle.
- R2: `io_reset_n` stays low from the wake cycle through the RELEASE_CYCLES cycles spent in POWER_UP_DELAY. It first reads high in the cycle after the last of those, when `state_o` reads WAIT_RSTDRV_LOW (code 2).
- R3: `cpu_rst_drv` passes through a two-flop synchronizer. If it falls in cycle w while the state is WAIT_RSTDRV_LOW, the state is still WAIT_RSTDRV_LOW in cycle w+2 and reads RUN (code 3) in cycle w+3.
- R4: In RUN, with the synchronized reset-drive low, a press drives `io_reset_n` low in that same cycle while `supply_en` stays high. `state_o` reads OFF_REFRESH_WAIT (code 4) in the next cycle.
- R5: In OFF_REFRESH_WAIT, `supply_en` stays high through the cycle of the second `refresh_strobe` pulse and is low (state OFF, code 0) in the next cycle. Strobes seen outside OFF_REFRESH_WAIT are not counted.
- R6: In RUN, a press that arrives while the synchronized reset-drive is high leaves `io_reset_n` high. The press is held and carried out in the first cycle in which the synchronized reset-drive reads low.
- R7: A press during POWER_UP_DELAY or WAIT_RSTDRV_LOW does not shorten the release delay and does not hold the I/O reset low; it is queued. This includes a press that coincides with the synchronized reset-drive falling. A queued press drives `io_reset_n` low in the first RUN cycle.
- R8: In OFF, an `ext_wake` pulse starts the same wake sequence as a press. In any other state, `ext_wake` has no effect.
- R9: Presses during OFF_REFRESH_WAIT are ignored: the controller reaches OFF and remains there without starting a new wake.
- R10: `state_o` encodes OFF=0, POWER_UP_DELAY=1, WAIT_RSTDRV_LOW=2, RUN=3, OFF_REFRESH_WAIT=4.
- R11: While `rst_n` is low and after its release, the controller is in OFF with `supply_en` low and `io_reset_n` low.
- R12: Elaboration fails if RELEASE_CYCLES is shorter than MIN_RELEASE_NS at CLK_HZ, or if it does not fit in DELAY_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_pulse | input | 1 | Synchronized single-cycle button press |
| ext_wake | input | 1 | External reset pulse, used as a wake request when off |
| cpu_rst_drv | input | 1 | Processor reset-drive output, active high, asynchronous |
| refresh_strobe | input | 1 | One-cycle pulse per memory refresh cycle |
| supply_en | output | 1 | Main supply enable |
| io_reset_n | output | 1 | Active-low I/O reset to the processor |
| state_o | output | 3 | Sequencer state code |

## Verification
`supply_en` and a power-off assertion of `io_reset_n` respond in the same cycle as the press, because both are decoded directly from the inputs. State changes appear one cycle later. The release of `io_reset_n` appears RELEASE_CYCLES+1 cycles after the wake cycle. RUN is reached three cycles after reset-drive falls, and the supply drops in the cycle after the second refresh strobe. The bench drives inputs just after a rising edge and samples on the falling edge. Every expectation is queued with the exact cycle in which it falls due, so each result is compared in the cycle the requirement names, and both sides of each boundary are checked.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_PUP   = 3'd1,
      ST_WAIT  = 3'd2,
      ST_RUN   = 3'd3,
      ST_DRAIN = 3'd4
   } seq_state_e;
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwr_seq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= {STAGES{RST_VAL}};
      else        sr_q <= {sr_q[STAGES-2:0], d_i};
   end

   assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
   parameter int W      = 27,
   parameter int CYCLES = 90_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic run_i,
   output logic done_o
);
   localparam logic [W-1:0] LOAD_VAL = W'(CYCLES - 1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= LOAD_VAL;
      else if (load_i)                cnt_q <= LOAD_VAL;
      else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

   // R2: the release delay counts down one step per running cycle
   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && run_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pwr_seq_refresh_cnt.sv
module pwr_seq_refresh_cnt #(
   parameter int COUNT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic strobe_i,
   output logic last_o
);
   generate
      if (COUNT < 1) begin : g_bad_count
         $error("pwr_seq_refresh_cnt: COUNT must be at least 1");
      end else if (COUNT == 1) begin : g_single
         assign last_o = strobe_i && !clear_i;
      end else begin : g_multi
         localparam int CW = $clog2(COUNT);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt_q <= '0;
            else if (clear_i)  cnt_q <= '0;
            else if (strobe_i) cnt_q <= cnt_q + 1'b1;
         end

         assign last_o = strobe_i && !clear_i && (cnt_q == CW'(COUNT - 1));

         // R5: every counted strobe advances the tally by exactly one
         a_r5_strobe_step: assert property (@(posedge clk) disable iff (!rst_n)
            (strobe_i && !clear_i && !last_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
      end
   endgenerate
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
   import pwr_seq_pkg::*;
#(
   parameter int CLK_HZ         = 200_000_000,
   parameter int MIN_RELEASE_NS = 5_000,
   parameter int DELAY_W        = 27,
   parameter int RELEASE_CYCLES = 90_000_000,
   parameter int OFF_REFRESHES  = 2,
   parameter int SYNC_STAGES    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       btn_pulse,
   input  logic       ext_wake,
   input  logic       cpu_rst_drv,
   input  logic       refresh_strobe,
   output logic       supply_en,
   output logic       io_reset_n,
   output logic [2:0] state_o
);
   localparam longint unsigned MIN_CYC =
      (64'(CLK_HZ) * 64'(MIN_RELEASE_NS) + 64'd999_999_999) / 64'd1_000_000_000;
   localparam longint unsigned MAX_CYC = 64'd1 << DELAY_W;

   // R12: elaboration-time parameter checks
   generate
      if (RELEASE_CYCLES < 1 || 64'(RELEASE_CYCLES) < MIN_CYC) begin : g_r12_too_short
         $error("pwr_seq_ctrl: RELEASE_CYCLES below the minimum reset hold time");
      end
      if (64'(RELEASE_CYCLES) > MAX_CYC) begin : g_r12_too_wide
         $error("pwr_seq_ctrl: RELEASE_CYCLES does not fit in DELAY_W bits");
      end
   endgenerate

   seq_state_e state_q, state_d;
   logic       pend_q;
   logic       rst_sync;
   logic       tmr_done;
   logic       ref_last;
   logic       wake;
   logic       off_go;

   pwr_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cpu_rst_drv),
      .q_o   (rst_sync)
   );

   pwr_seq_timer #(.W(DELAY_W), .CYCLES(RELEASE_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (state_q == ST_OFF),
      .run_i  (state_q == ST_PUP),
      .done_o (tmr_done)
   );

   pwr_seq_refresh_cnt #(.COUNT(OFF_REFRESHES)) u_refresh (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (state_q != ST_DRAIN),
      .strobe_i (refresh_strobe),
      .last_o   (ref_last)
   );

   assign wake   = btn_pulse || ext_wake;
   assign off_go = (state_q == ST_RUN) && (btn_pulse || pend_q) && !rst_sync;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_OFF:   if (wake)      state_d = ST_PUP;
         ST_PUP:   if (tmr_done)  state_d = ST_WAIT;
         ST_WAIT:  if (!rst_sync) state_d = ST_RUN;
         ST_RUN:   if (off_go)    state_d = ST_DRAIN;
         ST_DRAIN: if (ref_last)  state_d = ST_OFF;
         default:                 state_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OFF;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_OFF || state_q == ST_DRAIN || off_go)
            pend_q <= 1'b0;
         else if (btn_pulse)
            pend_q <= 1'b1;
      end
   end

   assign supply_en  = (state_q != ST_OFF) || wake;
   assign io_reset_n = (state_q == ST_WAIT) || ((state_q == ST_RUN) && !off_go);
   assign state_o    = state_q;

   // R1: a wake request in OFF always starts the release delay
   a_r1_wake_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OFF && wake) |=> (state_q == ST_PUP));

   // R2/R7: the delay state is left only when the timer has expired
   a_r2_hold_until_timer: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PUP && !tmr_done) |=> (state_q == ST_PUP));

   // R6: no power-off while the synchronized reset-drive is high
   a_r6_interlock: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && rst_sync) |=> (state_q == ST_RUN));

   // R5: the supply stays on until the final refresh strobe
   a_r5_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DRAIN && !refresh_strobe) |=> (state_q == ST_DRAIN && supply_en));

   // R11: the I/O reset is never released while the supply is off
   a_r11_reset_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!supply_en) |-> (!io_reset_n));
endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;
   import pwr_seq_pkg::*;

   localparam int REL = 1200;  // 6 us at 200 MHz, above the 5 us floor

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic btn_pulse = 1'b0;
   logic ext_wake = 1'b0;
   logic cpu_rst_drv = 1'b1;
   logic refresh_strobe = 1'b0;
   logic supply_en, io_reset_n;
   logic [2:0] state_o;

   always #2.5 clk = ~clk;

   pwr_seq_ctrl #(
      .CLK_HZ(200_000_000), .MIN_RELEASE_NS(5_000), .DELAY_W(11),
      .RELEASE_CYCLES(REL), .OFF_REFRESHES(2), .SYNC_STAGES(2)
   ) i_pwr_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .btn_pulse(btn_pulse), .ext_wake(ext_wake),
      .cpu_rst_drv(cpu_rst_drv), .refresh_strobe(refresh_strobe),
      .supply_en(supply_en), .io_reset_n(io_reset_n), .state_o(state_o)
   );

   typedef struct {
      int         due;
      logic [2:0] st;
      logic       sup;
      logic       ior;
   } exp_t;

   exp_t  sb_q[$];
   string tag_q[$];
   int    cyc = 0;
   int    checks = 0;
   int    failures = 0;
   bit    finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic expect_at(int due, logic [2:0] st, logic sup, logic ior, string tag);
      exp_t e;
      int   i;
      e.due = due; e.st = st; e.sup = sup; e.ior = ior;
      i = 0;
      while (i < sb_q.size() && sb_q[i].due <= due) i++;
      sb_q.insert(i, e);
      tag_q.insert(i, tag);
   endtask

   // monitor: compares every expectation in the cycle it falls due
   always @(negedge clk) begin
      while (rst_n && sb_q.size() > 0 && sb_q[0].due <= cyc) begin
         checks++;
         if (state_o !== sb_q[0].st || supply_en !== sb_q[0].sup ||
             io_reset_n !== sb_q[0].ior) begin
            failures++;
            $display("FAIL %s cyc=%0d actual st=%0d sup=%b ior=%b expected st=%0d sup=%b ior=%b",
                     tag_q[0], cyc, state_o, supply_en, io_reset_n,
                     sb_q[0].st, sb_q[0].sup, sb_q[0].ior);
         end
         void'(sb_q.pop_front());
         void'(tag_q.pop_front());
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_until(int abs_cyc);
      while (cyc < abs_cyc) tick(1);
   endtask

   // wake from OFF and reach WAIT_RSTDRV_LOW; optional second press at c+extra
   task automatic wake_to_wait(bit use_ext, int extra);
      int c;
      c = cyc;
      expect_at(c, ST_OFF, 1'b1, 1'b0, use_ext ? "R8 ext wake supply" : "R1 supply same cycle");
      expect_at(c + 1, ST_PUP, 1'b1, 1'b0, "R1 enters delay / R10 code 1");
      expect_at(c + REL, ST_PUP, 1'b1, 1'b0, "R2 reset held last delay cycle");
      expect_at(c + REL + 1, ST_WAIT, 1'b1, 1'b1, "R2 reset released / R7 not cut short");
      if (use_ext) ext_wake = 1'b1; else btn_pulse = 1'b1;
      tick(1);
      ext_wake = 1'b0; btn_pulse = 1'b0;
      if (extra > 0) begin
         wait_until(c + extra);
         expect_at(cyc, ST_PUP, 1'b1, 1'b0, "R7 press in delay keeps reset");
         btn_pulse = 1'b1;
         tick(1);
         btn_pulse = 1'b0;
      end
      wait_until(c + REL + 1);
   endtask

   // two refresh strobes in OFF_REFRESH_WAIT, then OFF
   task automatic drain_off();
      int s;
      s = cyc;
      expect_at(s, ST_DRAIN, 1'b1, 1'b0, "R5 first strobe");
      refresh_strobe = 1'b1; tick(1); refresh_strobe = 1'b0;
      expect_at(s + 1, ST_DRAIN, 1'b1, 1'b0, "R5 one strobe not enough");
      tick(1);
      expect_at(s + 2, ST_DRAIN, 1'b1, 1'b0, "R5 supply on at second strobe");
      expect_at(s + 3, ST_OFF, 1'b0, 1'b0, "R5 supply off after second strobe");
      refresh_strobe = 1'b1; tick(1); refresh_strobe = 1'b0;
      tick(2);
      cpu_rst_drv = 1'b1;
      tick(2);
   endtask

   initial begin
      int w;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      expect_at(cyc, ST_OFF, 1'b0, 1'b0, "R11 reset state");
      tick(3);

      // T1: press inside the delay window is queued (R7), served in first RUN cycle
      wake_to_wait(1'b0, 5);
      tick(4);
      w = cyc;
      cpu_rst_drv = 1'b0;
      expect_at(w + 2, ST_WAIT, 1'b1, 1'b1, "R3 two-flop sync latency");
      expect_at(w + 3, ST_RUN, 1'b1, 1'b0, "R7 queued press in first RUN / R3");
      expect_at(w + 4, ST_DRAIN, 1'b1, 1'b0, "R4 refresh wait / R10 code 4");
      wait_until(w + 6);
      drain_off();

      // T2: press while reset-drive is high is held off (R6)
      wake_to_wait(1'b0, 0);
      w = cyc;
      cpu_rst_drv = 1'b0;
      expect_at(w + 3, ST_RUN, 1'b1, 1'b1, "R3 RUN reached / R10 code 3");
      wait_until(w + 5);
      cpu_rst_drv = 1'b1;
      wait_until(w + 8);
      expect_at(w + 8, ST_RUN, 1'b1, 1'b1, "R6 press held, reset not asserted");
      expect_at(w + 9, ST_RUN, 1'b1, 1'b1, "R6 still held");
      btn_pulse = 1'b1; tick(1); btn_pulse = 1'b0;
      wait_until(w + 10);
      cpu_rst_drv = 1'b0;
      expect_at(w + 11, ST_RUN, 1'b1, 1'b1, "R6 held until sync low");
      expect_at(w + 12, ST_RUN, 1'b1, 1'b0, "R6 held press released");
      expect_at(w + 13, ST_DRAIN, 1'b1, 1'b0, "R6 power-off proceeds");
      wait_until(w + 13);
      drain_off();

      // T3: external wake (R8), press on the reset-drive falling edge (R7), press in drain (R9)
      wake_to_wait(1'b1, 0);
      w = cyc;
      cpu_rst_drv = 1'b0;
      wait_until(w + 2);
      expect_at(w + 2, ST_WAIT, 1'b1, 1'b1, "R7 race press keeps reset released");
      expect_at(w + 3, ST_RUN, 1'b1, 1'b0, "R7 race press served in RUN");
      expect_at(w + 4, ST_DRAIN, 1'b1, 1'b0, "R7 race press power-off");
      btn_pulse = 1'b1; tick(1); btn_pulse = 1'b0;
      wait_until(w + 5);
      expect_at(w + 6, ST_DRAIN, 1'b1, 1'b0, "R9 press in drain ignored");
      btn_pulse = 1'b1; tick(1); btn_pulse = 1'b0;
      wait_until(w + 6);
      drain_off();
      expect_at(cyc + 3, ST_OFF, 1'b0, 1'b0, "R9 stays off after drain press");
      tick(5);

      // T4: strobe and ext_wake outside their states are ignored (R5, R8), then press (R4)
      wake_to_wait(1'b0, 0);
      w = cyc;
      cpu_rst_drv = 1'b0;
      wait_until(w + 4);
      refresh_strobe = 1'b1; tick(1); refresh_strobe = 1'b0;
      expect_at(w + 5, ST_RUN, 1'b1, 1'b1, "R5 strobe in RUN no effect");
      wait_until(w + 6);
      expect_at(w + 6, ST_RUN, 1'b1, 1'b1, "R8 ext_wake in RUN same cycle");
      expect_at(w + 7, ST_RUN, 1'b1, 1'b1, "R8 ext_wake in RUN ignored");
      ext_wake = 1'b1; tick(1); ext_wake = 1'b0;
      wait_until(w + 8);
      expect_at(w + 8, ST_RUN, 1'b1, 1'b0, "R4 reset asserted same cycle");
      expect_at(w + 9, ST_DRAIN, 1'b1, 1'b0, "R4 refresh wait next cycle");
      btn_pulse = 1'b1; tick(1); btn_pulse = 1'b0;
      wait_until(w + 10);
      drain_off();

      tick(4);
      if (sb_q.size() != 0) begin
         failures++;
         checks++;
         $display("FAIL R10 scoreboard actual=%0d pending expected=0", sb_q.size());
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200_000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule